// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Decoder

This block sits between a flat memory-mapped configuration window and a configuration-space port. Each access carries a 32-bit offset into the window, and the routing information is packed into that offset: the bus, the device slot, the function, a 10-bit register index and the starting byte lane. No address is latched beforehand and there is no enable bit. The block splits the offset into these fields, rejects accesses that cannot be served, and sends one register-wide read or write to the downstream port. Writes carry byte enables. Read data is shifted so that the byte at the starting lane comes out in the lowest byte of the response.

Requests arrive on a valid/ready channel. A request is taken in any cycle where `req_valid` and `req_ready` are both high. A taken read fills a one-entry response register, which is presented on `rsp_valid`/`rsp_rdata`. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` is held low, so no new request is taken until the pending response is consumed. A taken write completes in its acceptance cycle and produces no response. The downstream port answers in the same cycle: `cfg_present` and `cfg_rdata` are combinational functions of `cfg_dev` and `cfg_reg`.

Top module: `cfgwin_decoder`

## Requirements
- R1: The offset decodes as bus = bits [27:20], device = bits [19:15], function = bits [14:12], register index = bits [11:2] (10 bits) and starting lane = bits [1:0]. Bits [31:28] are ignored. `cfg_dev` and `cfg_reg` always carry the decoded device and register index.
- R2: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is reserved. If lane plus length is greater than 4, or the size is reserved, a read returns 0xFF in every requested byte (all four bytes for the reserved size) and a write is dropped.
- R3: An access whose bus field is nonzero is refused. A refused read returns 0xFF in every requested byte, so a 4-byte read gives 0xFFFFFFFF. A refused write raises no `cfg_wr`.
- R4: An access whose function field is nonzero is refused under the same rules as R3.
- R5: If `cfg_present` is low for the decoded device, a read returns 0xFF in every requested byte and a write raises no `cfg_wr`.
- R6: For a served read, response byte i (i below the length) is byte (lane + i) of `cfg_rdata`, taken in little-endian order. Response bytes at or above the length are zero.
- R7: A served write sets `cfg_be` bits lane through lane+length-1 and places `req_wdata` byte i on `cfg_wdata` byte lane+i. A 1-byte write to register 15, lane 0, of device 0 reads back the written byte with the other three bytes unchanged.
- R8: A read taken in cycle n raises `rsp_valid` in cycle n+1. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. The response stays stable while it is stalled. A taken write leaves no response behind.
- R9: `cfg_rd` and `cfg_wr` are high only in the cycle a request is taken, never both at once, and only for a valid, present target.
- R10: During reset and right after it, `rsp_valid`, `cfg_rd` and `cfg_wr` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 32 | Window offset carrying bus, device, function, register index and lane |
| req_size | input | 2 | Access length code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved) |
| req_wdata | input | 32 | Write data, low-justified |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Read response consumed |
| rsp_rdata | output | 32 | Read data, low-justified |
| cfg_dev | output | 5 | Downstream device slot |
| cfg_reg | output | 10 | Downstream register index |
| cfg_rd | output | 1 | Downstream read strobe |
| cfg_wr | output | 1 | Downstream write strobe |
| cfg_be | output | 4 | Downstream byte enables |
| cfg_wdata | output | 32 | Downstream write data, lane-aligned |
| cfg_rdata | input | 32 | Downstream register contents |
| cfg_present | input | 1 | Decoded device slot is populated |

## Verification
The case that is hardest to reach from the ports is a stalled response with a second request already waiting behind it. The stimulus produces it by dropping `rsp_ready` before a read, then presenting a different read while the first response is still pending. Over several cycles it confirms that `req_ready` stays low, that no downstream strobe is raised, and that the held data does not change. It then releases `rsp_ready`, so the old response is consumed and the new request is taken on the same edge. Dropped writes leave no trace in the response, so they are checked in two ways: the bench samples the strobe during the acceptance cycle, and it reads the targeted register back afterwards.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int unsigned CW_BUS_LSB  = 20;
  localparam int unsigned CW_BUS_W    = 8;
  localparam int unsigned CW_DEV_LSB  = 15;
  localparam int unsigned CW_DEV_W    = 5;
  localparam int unsigned CW_FUNC_LSB = 12;
  localparam int unsigned CW_FUNC_W   = 3;
  localparam int unsigned CW_REG_LSB  = 2;
  localparam int unsigned CW_REG_W    = 10;
  localparam int unsigned CW_LANE_W   = 2;
  localparam int unsigned CW_LEN_W    = CW_LANE_W + 1;
  localparam int unsigned CW_BYTES    = 1 << CW_LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } cw_size_e;

  typedef struct packed {
    logic [CW_BUS_W-1:0]  bus;
    logic [CW_DEV_W-1:0]  dev;
    logic [CW_FUNC_W-1:0] func;
    logic [CW_REG_W-1:0]  regi;
    logic [CW_LANE_W-1:0] lane;
  } cw_fields_t;

  function automatic logic [CW_LEN_W-1:0] cw_len(input cw_size_e s);
    case (s)
      SZ_BYTE: return CW_LEN_W'(1);
      SZ_HALF: return CW_LEN_W'(2);
      default: return CW_LEN_W'(CW_BYTES);
    endcase
  endfunction

endpackage

// File: rtl/cfgwin_field_decode.sv
module cfgwin_field_decode
  import cfgwin_pkg::*;
(
  input  logic [31:0]          offset,
  input  cw_size_e             size,
  output cw_fields_t           fields,
  output logic [CW_LEN_W-1:0]  len,
  output logic                 lane_err,
  output logic                 target_ok
);

  logic unused_top_bits;
  assign unused_top_bits = ^offset[31:28];

  assign fields.bus  = offset[CW_BUS_LSB  +: CW_BUS_W];
  assign fields.dev  = offset[CW_DEV_LSB  +: CW_DEV_W];
  assign fields.func = offset[CW_FUNC_LSB +: CW_FUNC_W];
  assign fields.regi = offset[CW_REG_LSB  +: CW_REG_W];
  assign fields.lane = offset[0 +: CW_LANE_W];

  assign len = cw_len(size);

  // lane + length computed one bit wider so it cannot wrap
  logic [CW_LEN_W:0] span;
  assign span = {2'b00, fields.lane} + {1'b0, len};

  always_comb begin
    lane_err = (size == SZ_RSVD) || (span > (CW_LEN_W + 1)'(CW_BYTES));
  end

  assign target_ok = (fields.bus == '0) && (fields.func == '0);

endmodule

// File: rtl/cfgwin_lane_map.sv
module cfgwin_lane_map #(
  parameter  int unsigned BYTES = 4,
  localparam int unsigned LW    = $clog2(BYTES),
  localparam int unsigned LENW  = LW + 1,
  localparam int unsigned XW    = LENW + 1,
  localparam int unsigned DW    = 8 * BYTES
) (
  input  logic [LW-1:0]   lane,
  input  logic [LENW-1:0] len,
  input  logic            rd_err,
  input  logic [DW-1:0]   wdata_in,
  input  logic [DW-1:0]   rdata_in,
  output logic [BYTES-1:0] be,
  output logic [DW-1:0]   wdata_out,
  output logic [DW-1:0]   rdata_out
);

  logic [XW-1:0] lo;
  logic [XW-1:0] hi;
  logic [XW-1:0] ln;
  logic [DW-1:0] rshift;

  assign lo = XW'(lane);
  assign ln = XW'(len);
  assign hi = lo + ln;

  assign wdata_out = wdata_in << {lane, 3'b000};
  assign rshift    = rdata_in >> {lane, 3'b000};

  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    // enable window for the downstream side
    assign be[j] = (XW'(j) >= lo) && (XW'(j) < hi);
    // low-justified response byte
    assign rdata_out[8*j +: 8] = (XW'(j) >= ln) ? 8'h00 :
                                 (rd_err ? 8'hFF : rshift[8*j +: 8]);
  end

endmodule

// File: rtl/cfgwin_rsp_stage.sv
module cfgwin_rsp_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         can_load,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);

  assign can_load = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8
  load_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!rsp_valid || rsp_ready));

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned BYTES  = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [31:0]          req_offset,
  input  logic [1:0]           req_size,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [CW_DEV_W-1:0]  cfg_dev,
  output logic [CW_REG_W-1:0]  cfg_reg,
  output logic                 cfg_rd,
  output logic                 cfg_wr,
  output logic [BYTES-1:0]     cfg_be,
  output logic [DATA_W-1:0]    cfg_wdata,
  input  logic [DATA_W-1:0]    cfg_rdata,
  input  logic                 cfg_present
);

  cw_fields_t          fld;
  logic [CW_LEN_W-1:0] len;
  logic                lane_err;
  logic                target_ok;
  logic                accept;
  logic                served;
  logic [DATA_W-1:0]   steered;

  cfgwin_field_decode u_dec (
    .offset    (req_offset),
    .size      (cw_size_e'(req_size)),
    .fields    (fld),
    .len       (len),
    .lane_err  (lane_err),
    .target_ok (target_ok)
  );

  assign cfg_dev = fld.dev;
  assign cfg_reg = fld.regi;

  assign accept = req_valid && req_ready;
  assign served = target_ok && !lane_err && cfg_present;
  assign cfg_rd = accept && !req_write && served;
  assign cfg_wr = accept &&  req_write && served;

  cfgwin_lane_map #(.BYTES(BYTES)) u_map (
    .lane      (fld.lane),
    .len       (len),
    .rd_err    (!served),
    .wdata_in  (req_wdata),
    .rdata_in  (cfg_rdata),
    .be        (cfg_be),
    .wdata_out (cfg_wdata),
    .rdata_out (steered)
  );

  cfgwin_rsp_stage #(.W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && !req_write),
    .load_data (steered),
    .can_load  (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_rdata)
  );

  // R3 R4
  wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> ((req_offset[CW_BUS_LSB +: CW_BUS_W] == '0) &&
                (req_offset[CW_FUNC_LSB +: CW_FUNC_W] == '0)));

  // R7
  wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (($countones(cfg_be) == 1) || ($countones(cfg_be) == 2) ||
                ($countones(cfg_be) == BYTES)));

  // R8
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rsp_valid);

  // R8
  wr_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !rsp_valid);

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) |-> (req_valid && !(cfg_rd && cfg_wr)));

endmodule

// File: tb/tb_cfgwin_decoder.sv
`timescale 1ns/1ps
module tb_cfgwin_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [4:0]  cfg_dev;
  logic [9:0]  cfg_reg;
  logic        cfg_rd;
  logic        cfg_wr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cfg_present;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfgwin_decoder dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_dev(cfg_dev), .cfg_reg(cfg_reg), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_present(cfg_present)
  );

  function automatic logic [31:0] pat(input int d, input int r);
    return {8'hC0 + 8'(d), r[7:0], 6'b0, r[9:8], 8'h5A};
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] b, input logic [4:0] d,
                                     input logic [2:0] f, input logic [9:0] r,
                                     input logic [1:0] l);
    return {4'h0, b, d, f, r, l};
  endfunction

  // downstream model: slots 0 and 1 populated, registers 0..15 writable
  logic [31:0] mem [2][16];
  initial begin
    for (int d = 0; d < 2; d++)
      for (int r = 0; r < 16; r++) mem[d][r] = pat(d, r);
  end
  assign cfg_present = (cfg_dev < 5'd2);
  assign cfg_rdata = !cfg_present ? 32'h0 :
                     (cfg_reg < 10'd16) ? mem[cfg_dev[0]][cfg_reg[3:0]] :
                     pat(int'(cfg_dev), int'(cfg_reg));
  always @(posedge clk) begin
    if (cfg_wr && cfg_present && cfg_reg < 10'd16)
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) mem[cfg_dev[0]][cfg_reg[3:0]][8*b +: 8] <= cfg_wdata[8*b +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] off, input logic [1:0] sz,
                    input logic [31:0] exp, input bit exp_rd, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = off; req_size = sz;
    #1;
    chk(cfg_rd == exp_rd, {req, " R9 read strobe"}, 32'(cfg_rd), 32'(exp_rd));
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_rdata == exp, req, rsp_rdata, exp);
  endtask

  task automatic wr(input logic [31:0] off, input logic [1:0] sz,
                    input logic [31:0] data, input bit exp_wr,
                    input logic [3:0] exp_be, input logic [31:0] exp_wd,
                    input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_size = sz;
    req_wdata = data;
    #1;
    chk(cfg_wr == exp_wr, {req, " write strobe"}, 32'(cfg_wr), 32'(exp_wr));
    if (exp_wr) begin
      chk(cfg_be == exp_be, {req, " byte enables"}, 32'(cfg_be), 32'(exp_be));
      chk((cfg_wdata & {{8{exp_be[3]}}, {8{exp_be[2]}}, {8{exp_be[1]}}, {8{exp_be[0]}}})
          == exp_wd, {req, " lane data"}, cfg_wdata, exp_wd);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(!rsp_valid, "R8 no response after write", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_reset;
    #1;
    chk(!rsp_valid && !cfg_rd && !cfg_wr, "R10 idle in reset",
        {29'b0, rsp_valid, cfg_rd, cfg_wr}, 32'h0);
    chk(req_ready, "R10 ready in reset", 32'(req_ready), 32'h1);
  endtask

  task automatic t_aligned;
    rd(mk(0, 0, 0, 0, 0), 2'd2, pat(0, 0), 1'b1, "R1 R6 aligned word dev0 reg0");
    rd(mk(0, 1, 0, 7, 0), 2'd2, pat(1, 7), 1'b1, "R1 R6 aligned word dev1 reg7");
  endtask

  task automatic t_lanes;
    logic [31:0] p;
    p = pat(1, 3);
    for (int k = 0; k < 4; k++)
      rd(mk(0, 1, 0, 3, 2'(k)), 2'd0, {24'h0, p[8*k +: 8]}, 1'b1, "R6 single byte lane");
    rd(mk(0, 1, 0, 3, 2), 2'd1, {16'h0, p[31:16]}, 1'b1, "R6 half lane2");
    rd(mk(0, 1, 0, 3, 1), 2'd1, {16'h0, p[23:8]},  1'b1, "R6 half lane1");
  endtask

  task automatic t_cross;
    rd(mk(0, 0, 0, 1, 3), 2'd1, 32'h0000FFFF, 1'b0, "R2 half crossing lane3");
    rd(mk(0, 0, 0, 1, 1), 2'd2, 32'hFFFFFFFF, 1'b0, "R2 word at lane1");
    rd(mk(0, 0, 0, 1, 2), 2'd2, 32'hFFFFFFFF, 1'b0, "R2 word at lane2");
    rd(mk(0, 0, 0, 1, 0), 2'd3, 32'hFFFFFFFF, 1'b0, "R2 reserved size");
  endtask

  task automatic t_refused_reads;
    rd(mk(1, 0, 0, 0, 0),    2'd2, 32'hFFFFFFFF, 1'b0, "R3 bus 1 word");
    rd(mk(8'h80, 0, 0, 0, 0), 2'd0, 32'h000000FF, 1'b0, "R3 bus 0x80 byte");
    rd(mk(0, 0, 1, 0, 0),    2'd2, 32'hFFFFFFFF, 1'b0, "R4 function 1");
    rd(mk(0, 1, 7, 2, 0),    2'd2, 32'hFFFFFFFF, 1'b0, "R4 function 7");
    rd(mk(0, 5, 0, 0, 0),    2'd2, 32'hFFFFFFFF, 1'b0, "R5 absent slot 5");
    rd(mk(0, 31, 0, 0, 2),   2'd1, 32'h0000FFFF, 1'b0, "R5 absent slot 31 half");
  endtask

  task automatic t_writes;
    logic [31:0] p;
    p = pat(0, 15);
    wr(mk(0, 0, 0, 15, 0), 2'd0, 32'h42, 1'b1, 4'b0001, 32'h42, "R7 byte write reg15");
    rd(mk(0, 0, 0, 15, 0), 2'd2, {p[31:8], 8'h42}, 1'b1, "R7 byte readback reg15");
    p = pat(1, 4);
    wr(mk(0, 1, 0, 4, 1), 2'd1, 32'hBEEF, 1'b1, 4'b0110, 32'h00BEEF00, "R7 half write lane1");
    rd(mk(0, 1, 0, 4, 0), 2'd2, {p[31:24], 16'hBEEF, p[7:0]}, 1'b1, "R7 half readback");
    wr(mk(0, 1, 0, 5, 0), 2'd2, 32'h11223344, 1'b1, 4'b1111, 32'h11223344, "R7 word write");
    rd(mk(0, 1, 0, 5, 0), 2'd2, 32'h11223344, 1'b1, "R7 word readback");
  endtask

  task automatic t_dropped_writes;
    logic [31:0] p;
    p = pat(0, 15);
    wr(mk(2, 0, 0, 15, 0), 2'd0, 32'h99, 1'b0, 4'h0, 32'h0, "R3 write on bus 2");
    wr(mk(0, 0, 3, 15, 0), 2'd0, 32'h99, 1'b0, 4'h0, 32'h0, "R4 write to function 3");
    wr(mk(0, 0, 0, 15, 2), 2'd2, 32'h99, 1'b0, 4'h0, 32'h0, "R2 crossing write");
    wr(mk(0, 0, 0, 15, 0), 2'd3, 32'h99, 1'b0, 4'h0, 32'h0, "R2 reserved write");
    wr(mk(0, 9, 0, 15, 0), 2'd0, 32'h99, 1'b0, 4'h0, 32'h0, "R5 write to absent slot");
    rd(mk(0, 0, 0, 15, 0), 2'd2, {p[31:8], 8'h42}, 1'b1, "R2 R3 R4 reg15 untouched");
  endtask

  task automatic t_wide_decode;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2;
    req_offset = 32'hF0000000 | mk(0, 1, 0, 10'h3FF, 0);
    #1;
    chk(cfg_dev == 5'd1 && cfg_reg == 10'h3FF, "R1 device and register fields",
        {17'h0, cfg_dev, cfg_reg}, {17'h0, 5'd1, 10'h3FF});
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_rdata == pat(1, 10'h3FF), "R1 top bits ignored, reg 0x3FF",
        rsp_rdata, pat(1, 10'h3FF));
  endtask

  task automatic t_backpressure;
    logic [31:0] a;
    logic [31:0] b;
    a = pat(1, 2);
    b = pat(1, 6);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_offset = mk(0, 1, 0, 2, 0);
    @(negedge clk);
    req_offset = mk(0, 1, 0, 6, 0);
    #1;
    chk(!req_ready, "R8 ready low while stalled", 32'(req_ready), 32'h0);
    chk(!cfg_rd, "R9 no strobe while stalled", 32'(cfg_rd), 32'h0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == a, "R8 response held under stall", rsp_rdata, a);
    end
    rsp_ready = 1'b1;
    #1;
    chk(req_ready, "R8 ready returns with rsp_ready", 32'(req_ready), 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_rdata == b, "R8 queued read after release", rsp_rdata, b);
    @(negedge clk);
    chk(!rsp_valid, "R8 response drained", 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10 idle after reset",
        {30'b0, rsp_valid, req_ready}, 32'h1);
    t_aligned();
    t_lanes();
    t_cross();
    t_refused_reads();
    t_writes();
    t_dropped_writes();
    t_wide_decode();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule